// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general register file of a 32-bit processor core. Software always sees sixteen registers, numbered 0 to 15, but which physical storage a number refers to depends on the processor mode. The mode arrives as a 5-bit code. Register 15 is the program counter, and it is one plain register shared by every mode. The fast-interrupt modes keep private copies of registers 8 to 14. The supervisor, interrupt, abort and undefined-instruction modes each keep private copies of registers 13 and 14 only. Each 26-bit mode uses the same storage as its 32-bit counterpart.

The file has two combinational read ports and one write port that takes effect at the clock edge. A force-user input lets a privileged block transfer reach the user-mode copies without leaving its mode. A mode code that is not one of the ten defined codes is treated as user mode, and the illegal-mode output is raised while it is present.

The file holds 31 physical registers of 32 bits: 15 user copies, 7 fast-interrupt copies, 8 private copies for the other four privileged banks, and the program counter.

Top module: `banked_regfile`

## Requirements
- R1: The mode codes (bits 4..0) map to banks as follows. 00000 and 10000 select the user bank. 00001 and 10001 select the fast-interrupt bank. 00010 and 10010 select the interrupt bank. 00011 and 10011 select the supervisor bank. 10111 selects the abort bank and 11011 selects the undefined bank.
- R2: In the fast-interrupt bank, registers 8 to 14 use private storage, and registers 0 to 7 are the shared user copies.
- R3: In the interrupt, supervisor, abort and undefined banks, only registers 13 and 14 are private to that bank. Registers 0 to 12 are the shared user copies.
- R4: Codes 00000 and 10000 reach exactly the same physical registers, and the user bank has no private storage.
- R5: Codes 00001, 00010 and 00011 reach the same storage as 10001, 10010 and 10011 respectively.
- R6: While force_user is 1, reads and writes go to the user copies whatever the mode code.
- R7: A read of the register being written in the same cycle returns the old value. The new value is returned from the next cycle on.
- R8: Any other mode code selects the user bank and drives illegal_mode to 1. illegal_mode is 0 for the ten defined codes, independent of force_user.
- R9: Reset (rst_n low) sets all 31 physical registers to zero.
- R10: Register 15 is a single program-counter register. It reads back the same value in every mode.
- R11: The two read ports are independent. When both select the same register they return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 5 | Current processor mode code |
| force_user | input | 1 | Route all accesses to the user copies |
| rd_a_idx | input | 4 | Logical register number, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical register number, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical register number to write |
| wr_data | input | 32 | Write data |
| illegal_mode | output | 1 | Mode code is not one of the ten defined codes |

## Verification
A fault in the mode-to-bank or register-to-storage mapping lands a write in the wrong physical register. It does not show at the ports until that register, or the one that should have been written, is read under a mode that reaches it. This can be many cycles after the faulty write. The bench therefore writes through one mode and reads back through every mode that shares the storage and every mode that must not. It compares both read ports and the illegal flag on every cycle against a reference model keyed by bank and register, so a misrouted write is reported at the first read that reaches the affected storage. A fault in the read-during-write behaviour shows in the very cycle of the write.

// File: rtl/banked_rf_pkg.sv
// Package: banked_rf_pkg
// Purpose: constants and types shared by the banked register file.
// Assumes: one program counter outside all banks; every private bank
//          holds a contiguous range of the higher register numbers.
package banked_rf_pkg;
    localparam int XLEN        = 32;
    localparam int NUM_LOGICAL = 16;
    localparam int LIDX_W      = $clog2(NUM_LOGICAL);
    localparam int MODE_W      = 5;

    localparam int USR_CNT     = NUM_LOGICAL - 1;          // R0..R14
    localparam int FIQ_FIRST   = 8;
    localparam int FIQ_CNT     = USR_CNT - FIQ_FIRST;      // R8..R14
    localparam int PRIV_FIRST  = 13;
    localparam int PRIV_CNT    = USR_CNT - PRIV_FIRST;     // R13..R14
    localparam int PRIV_BANKS  = 4;
    localparam int PHYS_GPR    = USR_CNT + FIQ_CNT + PRIV_BANKS * PRIV_CNT;
    localparam int PHYS_TOTAL  = PHYS_GPR + 1;             // plus PC
    localparam int PIDX_W      = $clog2(PHYS_TOTAL);
    localparam int PC_SLOT     = PHYS_GPR;

    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    localparam logic [MODE_W-1:0] MC_USR26 = 5'b00000;
    localparam logic [MODE_W-1:0] MC_FIQ26 = 5'b00001;
    localparam logic [MODE_W-1:0] MC_IRQ26 = 5'b00010;
    localparam logic [MODE_W-1:0] MC_SVC26 = 5'b00011;
    localparam logic [MODE_W-1:0] MC_USR   = 5'b10000;
    localparam logic [MODE_W-1:0] MC_FIQ   = 5'b10001;
    localparam logic [MODE_W-1:0] MC_IRQ   = 5'b10010;
    localparam logic [MODE_W-1:0] MC_SVC   = 5'b10011;
    localparam logic [MODE_W-1:0] MC_ABT   = 5'b10111;
    localparam logic [MODE_W-1:0] MC_UND   = 5'b11011;
endpackage

// File: rtl/rf_mode_decode.sv
// Module: rf_mode_decode
// Purpose: turns the 5-bit mode code into a bank selection and an
//          illegal-code flag; force_user overrides the bank only.
// Assumes: 26-bit and 32-bit codes of one mode share a bank.
module rf_mode_decode
    import banked_rf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              force_user,
    output bank_e             bank,
    output logic              illegal
);
    bank_e raw_bank;

    // Decode the mode code into its bank and flag unknown codes.
    always_comb begin
        illegal  = 1'b0;
        raw_bank = BANK_USR;
        case (mode)
            MC_USR26, MC_USR: raw_bank = BANK_USR;
            MC_FIQ26, MC_FIQ: raw_bank = BANK_FIQ;
            MC_IRQ26, MC_IRQ: raw_bank = BANK_IRQ;
            MC_SVC26, MC_SVC: raw_bank = BANK_SVC;
            MC_ABT:           raw_bank = BANK_ABT;
            MC_UND:           raw_bank = BANK_UND;
            default: begin
                raw_bank = BANK_USR;
                illegal  = 1'b1;
            end
        endcase
    end

    // Apply the user-bank override used by block transfers.
    always_comb bank = force_user ? BANK_USR : raw_bank;
endmodule

// File: rtl/rf_phys_map.sv
// Module: rf_phys_map
// Purpose: maps a logical register number and a bank to a physical slot.
// Assumes: slot layout is user R0..R14, fast-interrupt R8..R14, then
//          R13/R14 pairs for IRQ, SVC, ABT, UND, then the PC.
module rf_phys_map
    import banked_rf_pkg::*;
(
    input  bank_e             bank,
    input  logic [LIDX_W-1:0] lidx,
    output logic [PIDX_W-1:0] pidx
);
    localparam logic [LIDX_W-1:0] PC_LIDX   = LIDX_W'(NUM_LOGICAL - 1);
    localparam logic [LIDX_W-1:0] FIQ_LO    = LIDX_W'(FIQ_FIRST);
    localparam logic [LIDX_W-1:0] PRIV_LO   = LIDX_W'(PRIV_FIRST);
    localparam logic [PIDX_W-1:0] FIQ_BASE  = PIDX_W'(USR_CNT);
    localparam logic [PIDX_W-1:0] PRIV_BASE = PIDX_W'(USR_CNT + FIQ_CNT);

    logic [2:0] priv_slot;

    // Position of the bank among the two-register private banks.
    always_comb priv_slot = 3'(bank) - 3'(BANK_IRQ);

    // Choose the physical slot for this access.
    always_comb begin
        if (lidx == PC_LIDX) begin
            pidx = PIDX_W'(PC_SLOT);
        end else if (bank == BANK_FIQ && lidx >= FIQ_LO) begin
            pidx = FIQ_BASE + PIDX_W'(lidx - FIQ_LO);
        end else if (bank != BANK_USR && bank != BANK_FIQ && lidx >= PRIV_LO) begin
            pidx = PRIV_BASE + PIDX_W'(priv_slot) * PIDX_W'(PRIV_CNT)
                 + PIDX_W'(lidx - PRIV_LO);
        end else begin
            pidx = PIDX_W'(lidx);
        end
    end
endmodule

// File: rtl/rf_storage.sv
// Module: rf_storage
// Purpose: DEPTH flip-flop registers with one write and two
//          combinational read ports.
// Assumes: reads see the value before the clock edge of a write.
module rf_storage #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 31,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data
);
    logic [DEPTH-1:0][DATA_W-1:0] regs;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] q;
        // Hold one physical register; clear on reset, load on its write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                q <= wr_data;
            end
        end
        assign regs[g] = q;
    end

    // Read port A, zero for an out-of-range slot number.
    always_comb rd_a_data = (32'(rd_a_idx) < DEPTH) ? regs[rd_a_idx] : '0;
    // Read port B, zero for an out-of-range slot number.
    always_comb rd_b_data = (32'(rd_b_idx) < DEPTH) ? regs[rd_b_idx] : '0;
endmodule

// File: rtl/banked_regfile.sv
// Module: banked_regfile
// Purpose: sixteen logical registers over 31 physical ones, banked by
//          the processor mode code; two reads, one write.
// Assumes: synchronous active-low reset; mode and force_user are
//          stable around the clock edge like the other inputs.
module banked_regfile
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              force_user,
    input  logic [LIDX_W-1:0] rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [LIDX_W-1:0] rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [LIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              illegal_mode
);
    localparam int NPORT = 3;   // read A, read B, write

    bank_e             cur_bank;
    logic [LIDX_W-1:0] port_lidx [NPORT];
    logic [PIDX_W-1:0] port_pidx [NPORT];

    rf_mode_decode u_decode (
        .mode       (mode),
        .force_user (force_user),
        .bank       (cur_bank),
        .illegal    (illegal_mode)
    );

    assign port_lidx[0] = rd_a_idx;
    assign port_lidx[1] = rd_b_idx;
    assign port_lidx[2] = wr_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rf_phys_map u_map (
            .bank (cur_bank),
            .lidx (port_lidx[p]),
            .pidx (port_pidx[p])
        );
    end

    rf_storage #(
        .DATA_W (DATA_W),
        .DEPTH  (PHYS_TOTAL)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (port_pidx[2]),
        .wr_data   (wr_data),
        .rd_a_idx  (port_pidx[0]),
        .rd_a_data (rd_a_data),
        .rd_b_idx  (port_pidx[1]),
        .rd_b_data (rd_b_data)
    );
endmodule

// File: rtl/banked_regfile_chk.sv
// Module: banked_regfile_chk
// Purpose: port-level properties of the banked register file, bound
//          to every instance of banked_regfile.
// Assumes: only the top-level ports are observed.
module banked_regfile_chk
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode,
    input logic              force_user,
    input logic [LIDX_W-1:0] rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [LIDX_W-1:0] rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [LIDX_W-1:0] wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              illegal_mode
);
    logic code_known;
    logic out_of_reset_q;

    // Independent list of the ten defined codes.
    always_comb code_known = (mode == 5'h00) || (mode == 5'h01) || (mode == 5'h02)
                          || (mode == 5'h03) || (mode == 5'h10) || (mode == 5'h11)
                          || (mode == 5'h12) || (mode == 5'h13) || (mode == 5'h17)
                          || (mode == 5'h1B);

    // Marks the cycles that follow a cycle with reset released.
    always_ff @(posedge clk) out_of_reset_q <= rst_n;

    // R8
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_mode == !code_known);

    // R9
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_of_reset_q |-> (rd_a_data == '0 && rd_b_data == '0));

    // R11
    port_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_idx == rd_b_idx |-> rd_a_data == rd_b_data);

    // R10
    pc_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 4'hF) |=> (rd_a_idx != 4'hF || rd_a_data == $past(wr_data)));

    // R7
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == rd_a_idx)
        |=> (mode != $past(mode) || force_user != $past(force_user)
             || rd_a_idx != $past(rd_a_idx) || rd_a_data == $past(wr_data)));
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
    localparam int CLK_HALF = 10;   // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = 5'h10;
    logic        force_user = 1'b0;
    logic [3:0]  rd_a_idx = '0;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_idx = '0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        illegal_mode;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [int];
    logic [4:0] codes [10] = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h10,
                               5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};

    banked_regfile u_banked_regfile (.*);

    always #(CLK_HALF) clk = ~clk;

    function automatic int key_of(logic [4:0] m, logic f, int idx);
        int b = 0;
        if (!f) begin
            case (m)
                5'h01, 5'h11: b = 1;
                5'h02, 5'h12: b = 2;
                5'h03, 5'h13: b = 3;
                5'h17:        b = 4;
                5'h1B:        b = 5;
                default:      b = 0;
            endcase
        end
        if (idx == 15) return 1000;
        if (b == 1 && idx >= 8) return 100 + idx;
        if (b >= 2 && idx >= 13) return b * 100 + idx;
        return idx;
    endfunction

    function automatic logic [31:0] peek(int k);
        return model.exists(k) ? model[k] : 32'h0;
    endfunction

    function automatic logic legal(logic [4:0] m);
        foreach (codes[i]) if (codes[i] == m) return 1'b1;
        return 1'b0;
    endfunction

    // Reference model: apply the write of this edge.
    always @(posedge clk) begin
        if (!rst_n) model.delete();
        else if (wr_en) model[key_of(mode, force_user, int'(wr_idx))] = wr_data;
    end

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Inputs are already set at a falling edge; check, then move on.
    task automatic tick(string tag);
        #(CLK_HALF / 2);
        check(tag, "rd_a", rd_a_data, peek(key_of(mode, force_user, int'(rd_a_idx))));
        check(tag, "rd_b", rd_b_data, peek(key_of(mode, force_user, int'(rd_b_idx))));
        check(tag, "illegal", 32'(illegal_mode), 32'(!legal(mode)));
        @(negedge clk);
    endtask

    task automatic wr(logic [4:0] m, logic f, int idx, logic [31:0] d, string tag);
        mode = m; force_user = f; wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
        rd_a_idx = 4'(idx); rd_b_idx = 4'(idx);
        tick(tag);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [4:0] m, logic f, int a, int b, string tag);
        mode = m; force_user = f; wr_en = 1'b0; rd_a_idx = 4'(a); rd_b_idx = 4'(b);
        tick(tag);
    endtask

    initial begin
        #(CLK_HALF * 2 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            wr_en = 1'b1; wr_idx = 4'(i); wr_data = 32'hDEAD0000;
            rd(5'h10, 1'b0, i, 15, "R9 during reset");
        end
        wr_en = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) rd(5'h13, 1'b0, i, 15 - i, "R9 after reset");

        // User bank and its 26-bit alias
        for (int i = 0; i < 16; i++) wr(5'h10, 1'b0, i, 32'h1000 + i, "R7 R1 user write");
        for (int i = 0; i < 16; i++) rd(5'h00, 1'b0, i, i, "R4 R11 user26 read");

        // Fast-interrupt bank
        for (int i = 8; i < 15; i++) wr(5'h11, 1'b0, i, 32'hF100 + i, "R2 fiq write");
        for (int i = 0; i < 16; i++) rd(5'h01, 1'b0, i, 15 - i, "R5 R2 fiq26 read");
        for (int i = 0; i < 16; i++) rd(5'h10, 1'b0, i, i, "R2 user untouched");

        // Two-register private banks
        foreach (codes[c]) begin
            if (codes[c] inside {5'h12, 5'h13, 5'h17, 5'h1B}) begin
                wr(codes[c], 1'b0, 13, {27'h5A5A, codes[c]}, "R3 priv r13");
                wr(codes[c], 1'b0, 14, {27'h6B6B, codes[c]}, "R3 priv r14");
                wr(codes[c], 1'b0, 12, {27'h7C7C, codes[c]}, "R3 shared r12");
            end
        end
        foreach (codes[c])
            for (int i = 11; i < 16; i++) rd(codes[c], 1'b0, i, 27 - i, "R3 R5 bank readback");

        // Forced user access from privileged modes
        wr(5'h11, 1'b1, 10, 32'hABCD0010, "R6 forced write");
        wr(5'h13, 1'b1, 14, 32'hABCD0014, "R6 forced write");
        for (int i = 8; i < 16; i++) rd(5'h11, 1'b1, i, i, "R6 forced read");
        for (int i = 8; i < 16; i++) rd(5'h10, 1'b0, i, i, "R6 user sees forced");
        for (int i = 8; i < 16; i++) rd(5'h11, 1'b0, i, i, "R6 fiq unaffected");

        // Unknown codes
        wr(5'h04, 1'b0, 13, 32'hBAD00013, "R8 illegal write");
        wr(5'h1F, 1'b0, 9, 32'hBAD00009, "R8 illegal write");
        rd(5'h10, 1'b0, 13, 9, "R8 lands in user");
        rd(5'h1F, 1'b1, 13, 14, "R8 flag with force");

        // Read during write, then next cycle
        mode = 5'h17; force_user = 1'b0;
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h0BAD0BAD;
        rd_a_idx = 4'd13; rd_b_idx = 4'd13;
        tick("R7 old value same cycle");
        wr_en = 1'b0;
        tick("R7 new value next cycle");

        // Program counter in every mode
        wr(5'h1B, 1'b0, 15, 32'hC0DE0015, "R10 pc write");
        foreach (codes[c]) rd(codes[c], 1'b0, 15, 15, "R10 pc shared");

        // Mixed traffic
        for (int n = 0; n < 400; n++) begin
            mode = ($urandom_range(0, 7) == 0) ? 5'($urandom) : codes[$urandom_range(0, 9)];
            force_user = ($urandom_range(0, 5) == 0);
            wr_en = $urandom_range(0, 1) == 1;
            wr_idx = 4'($urandom); wr_data = $urandom;
            rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
            tick("R1 R11 mixed");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule